// File: doc/BRIEF.md
# Two-Voice Rotating Rhythm Player

This block plays one fixed 12-step on/off rhythm on two voices. Each voice keeps its copy of the rhythm in a circular 12-bit register. A downbeat strobe advances both voices by one step. The step that leaves each register is captured into a one-bit hit cell, and the hit cell is sounded, gated by the downbeat strobe, to drive an actuator. The first twelve downbeats after reset fill the two voice registers from a boot register. No separate load mode exists: each voice's serial input is the OR of its own top bit and the top bit of the boot register. The boot register drains to zero, so the same path first loads the voices and then keeps them circulating.

An extra-rotate request, taken on an upbeat strobe, turns only the second voice register one extra place. After that, the second voice plays the rhythm one step ahead of the first. Repeated requests build up a larger phase offset. Counting measures and deciding when to shift are the job of a controller outside this block.

Top module: `rhythm_phase_player`

## Requirements
- R1: While reset is held, and after it is released, both hit outputs are 0. The first downbeat strobe after reset sounds nothing on either voice.
- R2: The rhythm is 111011010110, read left to right. Bit 11 of the pattern parameter is the first step. The hit cell captured on downbeat n (n counted from 1 after reset) holds step (n-1) mod 12. It is sounded on the strobe of downbeat n+1, so the stream repeats with period 12 and has no gap between the loading pass and later passes.
- R3: On each downbeat, the boot register moves its top bit out and takes a 0 in at the bottom. Once it is empty it adds no further ones to the voices.
- R4: After loading, each voice register recirculates its contents without losing or adding any ones.
- R5: Each hit output equals that voice's hit cell ANDed with the downbeat strobe. It is 0 in every cycle without a downbeat strobe.
- R6: In a cycle with no downbeat strobe and no accepted extra rotation, no register changes. Idle cycles and plain upbeats leave the later hit stream unchanged.
- R7: An extra-rotate request sampled with an upbeat strobe, once loading is complete, advances the second voice by one step and leaves the first voice unchanged. After k such requests, the second voice's downbeat-n cell holds step (n-1+k) mod 12.
- R8: After the twelfth downbeat, both voice registers hold the full pattern in phase, and the two hit streams are identical until an extra rotation occurs.
- R9: An extra-rotate request made during the first twelve downbeats is ignored.
- R10: The extra-rotate request has no effect without an upbeat strobe. When a downbeat and an upbeat strobe arrive in the same cycle, the downbeat step is taken and the extra rotation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dn_stb | input | 1 | Downbeat strobe, one clock wide |
| up_stb | input | 1 | Upbeat strobe, one clock wide |
| extra_req | input | 1 | Request for one extra step of the second voice, sampled with the upbeat strobe |
| hit_a | output | 1 | First voice actuator drive |
| hit_b | output | 1 | Second voice actuator drive |

## Verification
The assertions assume that each strobe lasts a single clock and that the extra-rotate request matters only in a cycle that carries an upbeat strobe. Some checks also assume the strobes normally arrive in separate cycles. The stimulus raises each strobe for exactly one cycle at a falling edge, with an idle cycle in between. It pairs a downbeat with an upbeat only in the one scenario that checks downbeat priority. The properties on the first voice and on the loading window exclude the downbeat cycle explicitly, so that scenario does not violate them.

// File: rtl/rpp_pkg.sv
package rpp_pkg;
  localparam int unsigned DEF_STEPS = 12;
  // Leftmost written step sits in the top bit and is played first.
  localparam logic [DEF_STEPS-1:0] DEF_PATTERN = 12'b1110_1101_0110;
  localparam int unsigned NUM_VOICES = 2;
  // Index of the voice that takes extra rotations.
  localparam int unsigned SHIFT_VOICE = 1;
endpackage

// File: rtl/rpp_reset_sync.sv
module rpp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rpp_boot_shifter.sv
module rpp_boot_shifter #(
  parameter int unsigned        STEPS   = rpp_pkg::DEF_STEPS,
  parameter logic [STEPS-1:0]   PATTERN = rpp_pkg::DEF_PATTERN
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             dn_stb,
  output logic             boot_bit,
  output logic [STEPS-1:0] boot_o
);
  logic [STEPS-1:0] boot_q, boot_d;
  logic             boot_en;

  always_comb begin
    boot_en = dn_stb;
    boot_d  = {boot_q[STEPS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      boot_q <= PATTERN;
    else if (boot_en) boot_q <= boot_d;
  end

  assign boot_bit = boot_q[STEPS-1];
  assign boot_o   = boot_q;

  // R3: an empty boot register stays empty across downbeats
  p_boot_drains_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_stb && boot_q == '0) |=> boot_q == '0);
  // R6: no downbeat, no movement
  p_boot_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !dn_stb |=> $stable(boot_q));
endmodule

// File: rtl/rpp_load_tracker.sv
module rpp_load_tracker #(
  parameter int unsigned STEPS = rpp_pkg::DEF_STEPS
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic dn_stb,
  output logic loaded
);
  localparam int unsigned CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STEPS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = dn_stb && (cnt_q != CNT_FULL);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign loaded = (cnt_q == CNT_FULL);

  // R8: once loaded, the voices stay loaded until reset
  p_loaded_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    loaded |=> loaded);
  // R9: loading is never complete before twelve downbeats have passed
  p_not_early_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (!loaded && !dn_stb) |=> !loaded);
endmodule

// File: rtl/rpp_voice_ring.sv
module rpp_voice_ring #(
  parameter int unsigned STEPS     = rpp_pkg::DEF_STEPS,
  parameter bit          ROTATABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             dn_stb,
  input  logic             up_stb,
  input  logic             extra_req,
  input  logic             loaded,
  input  logic             boot_bit,
  output logic [STEPS-1:0] ring_o,
  output logic             hit_cell
);
  logic [STEPS-1:0] ring_q, ring_d;
  logic             hit_q, hit_d;
  logic             ser_in, extra_ok, ring_en, hit_en;

  always_comb begin
    ser_in   = ring_q[STEPS-1] | boot_bit;
    extra_ok = ROTATABLE && up_stb && extra_req && loaded && !dn_stb;
    ring_en  = dn_stb || extra_ok;
    hit_en   = dn_stb;
    hit_d    = ser_in;
    if (dn_stb) ring_d = {ring_q[STEPS-2:0], ser_in};
    else        ring_d = {ring_q[STEPS-2:0], ring_q[STEPS-1]};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      ring_q <= '0;
    else if (ring_en) ring_q <= ring_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     hit_q <= 1'b0;
    else if (hit_en) hit_q <= hit_d;
  end

  assign ring_o   = ring_q;
  assign hit_cell = hit_q;

  // R4: after loading, a rotation keeps the count of ones
  p_ones_kept_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (loaded && (dn_stb || up_stb)) |=> $countones(ring_q) == $past($countones(ring_q)));
  // R6: without strobes, the ring and the hit cell hold
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!dn_stb && !up_stb) |=> ($stable(ring_q) && $stable(hit_q)));
endmodule

// File: rtl/rhythm_phase_player.sv
module rhythm_phase_player #(
  parameter int unsigned                    STEPS   = rpp_pkg::DEF_STEPS,
  parameter logic [rpp_pkg::DEF_STEPS-1:0] PATTERN = rpp_pkg::DEF_PATTERN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dn_stb,
  input  logic up_stb,
  input  logic extra_req,
  output logic hit_a,
  output logic hit_b
);
  localparam int unsigned NV = rpp_pkg::NUM_VOICES;

  logic             rst_sn;
  logic             boot_bit;
  logic [STEPS-1:0] boot_val;
  logic             loaded;
  logic [STEPS-1:0] ring   [NV];
  logic             hit_cell [NV];

  rpp_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rpp_boot_shifter #(.STEPS(STEPS), .PATTERN(PATTERN)) u_boot (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .dn_stb   (dn_stb),
    .boot_bit (boot_bit),
    .boot_o   (boot_val)
  );

  rpp_load_tracker #(.STEPS(STEPS)) u_load (
    .clk    (clk),
    .rst_sn (rst_sn),
    .dn_stb (dn_stb),
    .loaded (loaded)
  );

  for (genvar v = 0; v < NV; v++) begin : g_voice
    rpp_voice_ring #(
      .STEPS     (STEPS),
      .ROTATABLE (v == rpp_pkg::SHIFT_VOICE)
    ) u_ring (
      .clk       (clk),
      .rst_sn    (rst_sn),
      .dn_stb    (dn_stb),
      .up_stb    (up_stb),
      .extra_req (extra_req),
      .loaded    (loaded),
      .boot_bit  (boot_bit),
      .ring_o    (ring[v]),
      .hit_cell  (hit_cell[v])
    );
  end

  assign hit_a = hit_cell[0] & dn_stb;
  assign hit_b = hit_cell[rpp_pkg::SHIFT_VOICE] & dn_stb;

  // R5: nothing sounds outside a downbeat strobe
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    !dn_stb |-> (!hit_a && !hit_b));
  // R7: the first voice never moves on an upbeat
  p_first_still_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (up_stb && !dn_stb) |=> $stable(ring[0]));
  // R8: at the moment loading completes, both voices hold the pattern
  p_in_phase_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(loaded) |-> (ring[0] == PATTERN && ring[1] == PATTERN && boot_val == '0));
  // R9: extra requests during loading leave the second voice alone
  p_load_ignore_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (!loaded && !dn_stb && up_stb && extra_req) |=> $stable(ring[1]));
  // R10: a downbeat and an upbeat together move both voices alike
  p_dn_wins_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (loaded && dn_stb && up_stb && ring[0] == ring[1]) |=> ring[0] == ring[1]);
endmodule

// File: tb/test_rhythm_phase_player.sv
`timescale 1ns/1ps
module test_rhythm_phase_player;
  localparam logic [11:0] PAT = 12'b1110_1101_0110;

  logic clk = 1'b0;
  logic rst_n, dn_stb, up_stb, extra_req;
  logic hit_a, hit_b;

  int checks = 0;
  int errors = 0;
  int n_dn   = 0;   // downbeats since reset
  int off_b  = 0;   // extra rotations accepted on the second voice
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rhythm_phase_player i_rhythm_phase_player (
    .clk       (clk),
    .rst_n     (rst_n),
    .dn_stb    (dn_stb),
    .up_stb    (up_stb),
    .extra_req (extra_req),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
  );

  function automatic logic step_bit(int n, int off);
    if (n == 0) return 1'b0;
    return PAT[11 - ((n - 1 + off) % 12)];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (downbeat %0d)", req, act, exp, n_dn);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dn_stb = 1'b0; up_stb = 1'b0; extra_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 hit_a in reset", hit_a, 1'b0);
    chk("R1 hit_b in reset", hit_b, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_dn = 0; off_b = 0;
  endtask

  // One downbeat; checks the gated outputs in the strobe cycle and after it.
  task automatic beat(string req, bit with_up = 1'b0, bit with_extra = 1'b0);
    @(negedge clk);
    dn_stb = 1'b1; up_stb = with_up; extra_req = with_extra;
    #1;
    chk(req, hit_a, step_bit(n_dn, 0));
    chk(req, hit_b, step_bit(n_dn, off_b));
    @(negedge clk);
    dn_stb = 1'b0; up_stb = 1'b0; extra_req = 1'b0;
    n_dn++;
    #1;
    chk("R5 hit_a off strobe", hit_a, 1'b0);
    chk("R5 hit_b off strobe", hit_b, 1'b0);
  endtask

  task automatic upbeat(bit with_extra);
    @(negedge clk);
    up_stb = 1'b1; extra_req = with_extra;
    @(negedge clk);
    up_stb = 1'b0; extra_req = 1'b0;
    if (with_extra && n_dn >= 12) off_b++;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 hit_a idle", hit_a, 1'b0);
    beat("R1 first strobe silent");
  endtask

  task automatic t_load_and_play();
    do_reset();
    for (int i = 0; i < 30; i++) begin
      if (i < 13) beat("R2 R3 loading pass");
      else        beat("R4 R8 recirculating pass");
      upbeat(1'b0);
    end
  endtask

  task automatic t_extra_in_load();
    do_reset();
    for (int i = 0; i < 5; i++) beat("R2 load");
    upbeat(1'b1);
    for (int i = 0; i < 20; i++) beat("R9 request in loading ignored");
  endtask

  task automatic t_extra_without_upbeat();
    do_reset();
    for (int i = 0; i < 14; i++) beat("R8 load");
    @(negedge clk); extra_req = 1'b1;
    repeat (3) @(negedge clk); extra_req = 1'b0;
    for (int i = 0; i < 13; i++) beat("R10 request alone ignored");
  endtask

  task automatic t_phase_shift();
    do_reset();
    for (int i = 0; i < 13; i++) beat("R8 load");
    upbeat(1'b1);
    for (int i = 0; i < 14; i++) beat("R7 one step ahead");
    upbeat(1'b0);
    beat("R6 plain upbeat no change");
    upbeat(1'b1);
    for (int i = 0; i < 14; i++) beat("R7 two steps ahead");
    repeat (20) @(negedge clk);
    chk("R6 idle hit_a", hit_a, 1'b0);
    for (int i = 0; i < 12; i++) beat("R6 after idle");
  endtask

  task automatic t_coincident();
    do_reset();
    for (int i = 0; i < 13; i++) beat("R8 load");
    beat("R10 downbeat with upbeat", 1'b1, 1'b1);
    for (int i = 0; i < 13; i++) beat("R10 no extra step taken");
  endtask

  initial begin
    rst_n = 1'b0; dn_stb = 1'b0; up_stb = 1'b0; extra_req = 1'b0;
    t_reset_state();
    t_load_and_play();
    t_extra_in_load();
    t_extra_without_upbeat();
    t_phase_shift();
    t_coincident();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule